// File: doc/BRIEF.md
# Reference-Gated Data Rate Meter

This block finds the rate of a recovered serial data clock by counting it against a reference clock that the user supplies. Both clocks reach the block as one-cycle tick enables in the system clock domain. When software arms a measurement, the block opens a gate that lasts a power-of-two number of reference ticks. It counts the data ticks that fall inside the gate. When the gate closes, it latches that count as a 23-bit result. The gate length is 2^(BASE_EXP + range) reference ticks, with BASE_EXP = 14 by default. Because of this length, the data rate equals the result times the reference frequency divided by 2^(BASE_EXP + range). The 2-bit range field covers references of 10–20, 20–40, 40–80 and 80–160 MHz. For example, a 32 MHz reference at range 1 with 622.08 Mb/s data gives about 0x9B851.

Software uses a small byte-wide register interface. Writes are synchronous and reads are combinational. Through it, software sets the range and a level-sensitive enable, and arms a measurement by writing the restart bit high and then low. It then polls the done flag and reads the result as three bytes. A separate valid output qualifies the result with the lock status of the recovery loop.

Top module: `rate_meter`

## Requirements
- R1: After arming, the gate spans exactly 2^(BASE_EXP + range) reference ticks. It starts in the cycle after the arming write and ends in the cycle of the last such tick. The result equals the number of data ticks seen in the cycles of the gate, that last cycle included.
- R2: Register 0 holds the enable at bit 0 and the range at bits 2:1. It reads back as written. Reset clears the enable, the range, the result and all status bits.
- R3: Address 3 returns result bits 22:16 in its low seven bits, with bit 7 at 0. Address 4 returns bits 15:8, and address 5 returns bits 7:0.
- R4: Writing address 1 with bit 0 = 1 clears done and stops any gate. A later write to address 1 with bit 0 = 0 arms a new gate. A write of 0 with no preceding 1 has no effect.
- R5: Status (address 2) bit 0 reads 0 while a gate runs and 1 once the result is final.
- R6: The valid output and status bit 2 are high exactly when done is 1 and loss_of_lock is 0.
- R7: If the count passes all ones, the result saturates at all ones and status bit 1 (overflow) is set. A measurement without overflow reads bit 1 as 0.
- R8: The result changes only at the end of a gate. The previous result stays readable while a new gate runs.
- R9: With the enable held at 1, repeated measurements can be armed without rewriting register 0. Clearing the enable aborts a running gate and holds done at 0. Arming with the enable at 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational register read data |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| data_tick | input | 1 | One-cycle pulse per recovered data clock event |
| loss_of_lock | input | 1 | High while the recovery loop is unlocked |
| result_valid | output | 1 | Result is final and the loop is locked |

## Verification
The bench builds the block with BASE_EXP = 3 and CNT_W = 10. This makes the four gates 8, 16, 32 and 64 reference ticks long, so every range setting finishes in a few hundred cycles. It also puts counter saturation within reach of a 1280-cycle gate. The reference and data tick patterns restart in step with the arming write. Each expected count is therefore the exact product of gate length, reference period and data density, which tests the scaling formula for every range. The byte layout is checked at the narrow width, so the top byte must read zero.

// File: rtl/rm_pkg.sv
package rm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_RHI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RMID = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLO  = 3'd5;

    typedef struct packed {
        logic [1:0] range_sel;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic valid;
        logic ovf;
        logic done;
    } stat_t;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_RUN  = 2'd1,
        WIN_DONE = 2'd2
    } win_state_e;

    // Byte idx of a 24-bit result; the top byte keeps only its low seven bits.
    function automatic logic [7:0] result_byte(input logic [23:0] r, input int idx);
        logic [7:0] b;
        b = r[8*idx +: 8];
        if (idx == 2) b[7] = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/rm_regs.sv
module rm_regs
    import rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output ctrl_t             ctrl,
    output logic              arm,
    output logic              restart_set
);
    logic restart_q;
    logic cmd_wr;

    wire unused_wr_hi = ^wr_data[7:3];

    assign cmd_wr      = wr_en && (wr_addr == A_CMD);
    assign restart_set = cmd_wr && wr_data[0];
    assign arm         = cmd_wr && !wr_data[0] && restart_q && ctrl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            restart_q <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_CTRL)) ctrl <= ctrl_t'(wr_data[2:0]);
            if (cmd_wr) restart_q <= wr_data[0];
        end
    end
endmodule

// File: rtl/rm_window.sv
module rm_window
    import rm_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       arm,
    input  logic       restart_set,
    input  logic       ref_tick,
    input  logic [1:0] range_sel,
    output win_state_e state,
    output logic       last
);
    localparam int RW = BASE_EXP + 3;

    logic [RW-1:0] ref_cnt;
    logic [RW-1:0] limit_m1;

    assign limit_m1 = (RW'(1) << (BASE_EXP + int'(range_sel))) - RW'(1);
    assign last     = (state == WIN_RUN) && ref_tick && (ref_cnt == limit_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WIN_IDLE;
            ref_cnt <= '0;
        end else if (!enable) begin
            state   <= WIN_IDLE;
        end else if (arm) begin
            state   <= WIN_RUN;
            ref_cnt <= '0;
        end else if (restart_set) begin
            state   <= WIN_IDLE;
        end else if (state == WIN_RUN) begin
            if (last) state <= WIN_DONE;
            else if (ref_tick) ref_cnt <= ref_cnt + RW'(1);
        end
    end
endmodule

// File: rtl/rm_satcnt.sv
module rm_satcnt #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_next,
    output logic         ovf_next
);
    logic [W-1:0] cnt;
    logic         ovf;
    logic         at_max;

    assign at_max   = (cnt == {W{1'b1}});
    assign cnt_next = (inc && !at_max) ? cnt + W'(1) : cnt;
    assign ovf_next = ovf || (inc && at_max);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_next;
            ovf <= ovf_next;
        end
    end
endmodule

// File: rtl/rate_meter.sv
module rate_meter
    import rm_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int CNT_W    = 23
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        ref_tick,
    input  logic        data_tick,
    input  logic        loss_of_lock,
    output logic        result_valid
);
    localparam int PAD_W = 24 - CNT_W;

    ctrl_t       ctrl_q;
    logic        en_lvl;
    logic        arm;
    logic        restart_set;
    win_state_e  win_state;
    logic        win_last;
    logic        active;
    logic        done;
    logic [CNT_W-1:0] cnt_next;
    logic        ovf_next;
    logic [CNT_W-1:0] result;
    logic        res_ovf;
    logic [23:0] res_wide;
    stat_t       stat;

    rm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl_q), .arm(arm), .restart_set(restart_set)
    );

    assign en_lvl = ctrl_q.enable;

    rm_window #(.BASE_EXP(BASE_EXP)) u_win (
        .clk(clk), .rst(rst), .enable(en_lvl), .arm(arm), .restart_set(restart_set),
        .ref_tick(ref_tick), .range_sel(ctrl_q.range_sel),
        .state(win_state), .last(win_last)
    );

    assign active = (win_state == WIN_RUN);
    assign done   = (win_state == WIN_DONE);

    rm_satcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(arm), .inc(data_tick && active),
        .cnt_next(cnt_next), .ovf_next(ovf_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            res_ovf <= 1'b0;
        end else if (win_last) begin
            result  <= cnt_next;
            res_ovf <= ovf_next;
        end
    end

    assign result_valid = done && !loss_of_lock;
    assign res_wide     = {{PAD_W{1'b0}}, result};
    assign stat         = '{valid: result_valid, ovf: res_ovf, done: done};

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {5'b0, ctrl_q};
            A_STAT:  rd_data = {5'b0, stat};
            A_RHI:   rd_data = result_byte(res_wide, 2);
            A_RMID:  rd_data = result_byte(res_wide, 1);
            A_RLO:   rd_data = result_byte(res_wide, 0);
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rate_meter_chk.sv
module rate_meter_chk #(
    parameter int CNT_W = 23
) (
    input logic             clk,
    input logic             rst,
    input logic             loss_of_lock,
    input logic             result_valid,
    input logic             enable,
    input logic             active,
    input logic             done,
    input logic [CNT_W-1:0] result,
    input logic             res_ovf
);
    // R6
    lol_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        loss_of_lock |-> !result_valid);

    // R9
    disable_aborts_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!done && !active));

    // R8
    result_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(done));

    // R7
    ovf_saturated_chk: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> (result == {CNT_W{1'b1}}));

    // R5
    done_after_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(active));
endmodule

bind rate_meter rate_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .loss_of_lock(loss_of_lock), .result_valid(result_valid),
    .enable(en_lvl), .active(active), .done(done), .result(result), .res_ovf(res_ovf)
);

// File: tb/rate_meter_bench.sv
`timescale 1ns/1ps
module rate_meter_bench;
    localparam int BASE_EXP = 3;
    localparam int CNT_W    = 10;
    localparam int NVEC     = 7;
    // columns: range, ref period, data ticks per period, data period, expected count, expected ovf
    localparam int VEC [NVEC][6] = '{
        '{0, 1, 1, 1,    8, 0},
        '{1, 1, 1, 2,    8, 0},
        '{2, 2, 1, 1,   64, 0},
        '{3, 4, 3, 4,  192, 0},
        '{1, 5, 2, 5,   32, 0},
        '{3, 3, 1, 1,  192, 0},
        '{3, 20, 1, 1, 1023, 1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ref_tick;
    logic       data_tick;
    logic       loss_of_lock = 1'b0;
    logic       result_valid;

    int tests = 0;
    int fails = 0;
    int ph = 0;
    int cur_r = 1, cur_d = 1, cur_p = 1;

    always #4 clk = ~clk;

    rate_meter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_rate_meter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ref_tick(ref_tick), .data_tick(data_tick),
        .loss_of_lock(loss_of_lock), .result_valid(result_valid)
    );

    // Tick phase restarts on the edge that takes a restart-low write.
    always @(posedge clk) begin
        if (wr_en && wr_addr == 3'd1 && !wr_data[0]) ph <= 0;
        else ph <= ph + 1;
    end
    assign ref_tick  = (ph % cur_r) == (cur_r - 1);
    assign data_tick = (ph % cur_p) < cur_d;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_result(output int val, output logic [7:0] hi);
        logic [7:0] m, l;
        rd(3'd3, hi); rd(3'd4, m); rd(3'd5, l);
        val = (int'(hi) << 16) | (int'(m) << 8) | int'(l);
    endtask

    task automatic arm_gate();
        wr(3'd1, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic wait_done(output bit seen);
        logic [7:0] s;
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(3'd2, s);
            if (s[0]) begin seen = 1'b1; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int val;
        logic [7:0] hi, s, c;
        bit seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: R2, R5, R6
        rd(3'd0, c);  check(c == 8'h00, "R2 ctrl reset", c, 0);
        rd(3'd2, s);  check(s == 8'h00, "R5 status reset", s, 0);
        rd_result(val, hi); check(val == 0, "R2 result reset", val, 0);
        check(result_valid == 1'b0, "R6 valid reset", result_valid, 0);

        // Table: R1 scaling per range, R3 bytes, R7 saturation, R6 valid
        for (int v = 0; v < NVEC; v++) begin
            cur_r = VEC[v][1]; cur_d = VEC[v][2]; cur_p = VEC[v][3];
            wr(3'd0, 8'((VEC[v][0] << 1) | 1));
            rd(3'd0, c); check(int'(c) == ((VEC[v][0] << 1) | 1), "R2 ctrl readback", c, (VEC[v][0] << 1) | 1);
            arm_gate();
            wait_done(seen);
            check(seen, "R5 done after gate", seen, 1);
            rd_result(val, hi);
            check(val == VEC[v][4], "R1 count", val, VEC[v][4]);
            check(hi[7] == 1'b0, "R3 top byte bit7", hi[7], 0);
            rd(3'd2, s);
            check(int'(s[1]) == VEC[v][5], "R7 overflow flag", s[1], VEC[v][5]);
            check(result_valid && s[2], "R6 valid when locked", result_valid, 1);
        end

        // R3 byte split of 1023 = 0x0003FF
        rd(3'd4, c); check(c == 8'h03, "R3 middle byte", c, 3);
        rd(3'd5, c); check(c == 8'hFF, "R3 low byte", c, 255);

        // R4 restart-high clears done; R8 old result held through the new gate
        cur_r = 1; cur_d = 1; cur_p = 1;
        wr(3'd1, 8'h01);
        rd(3'd2, s); check(s[0] == 1'b0, "R4 done cleared by restart", s[0], 0);
        wr(3'd1, 8'h00);
        idle(10);
        rd(3'd2, s); check(s[0] == 1'b0, "R5 done low mid-gate", s[0], 0);
        rd_result(val, hi); check(val == 1023, "R8 old result held", val, 1023);
        wait_done(seen);
        rd_result(val, hi); check(val == 64, "R1 count range3", val, 64);
        rd(3'd2, s); check(s[1] == 1'b0, "R7 overflow cleared", s[1], 0);

        // R9 repeat without rewriting ctrl
        cur_p = 2;
        arm_gate();
        wait_done(seen);
        rd_result(val, hi); check(seen && val == 32, "R9 repeat measurement", val, 32);

        // R4 low write without a preceding high does nothing
        wr(3'd1, 8'h00);
        idle(100);
        rd(3'd2, s); check(s[0] == 1'b1, "R4 lone low write ignored", s[0], 1);
        rd_result(val, hi); check(val == 32, "R4 result kept", val, 32);

        // R6 loss of lock
        @(negedge clk); loss_of_lock = 1'b1;
        rd(3'd2, s);
        check(!result_valid && !s[2], "R6 valid low on loss of lock", result_valid, 0);
        @(negedge clk); loss_of_lock = 1'b0;
        rd(3'd2, s);
        check(result_valid && s[2], "R6 valid back on lock", result_valid, 1);

        // R9 clearing enable aborts a running gate
        arm_gate();
        idle(10);
        wr(3'd0, 8'h06);
        idle(100);
        rd(3'd2, s); check(s[0] == 1'b0, "R9 abort holds done low", s[0], 0);
        check(result_valid == 1'b0, "R9 valid low after abort", result_valid, 0);
        rd_result(val, hi); check(val == 32, "R8 result unchanged by abort", val, 32);

        // R9 arming with enable low starts nothing
        arm_gate();
        idle(100);
        rd(3'd2, s); check(s[0] == 1'b0, "R9 no start while disabled", s[0], 0);

        // R2 range field at bits 2:1: range 0 gives an 8-tick gate
        cur_p = 1;
        wr(3'd0, 8'h01);
        arm_gate();
        wait_done(seen);
        rd_result(val, hi); check(seen && val == 8, "R2 range 0 gate", val, 8);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule